// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a clocked static RAM whose write data trails its write command, so reads and writes can be issued on back-to-back cycles with no idle cycle in between. Address, command and byte-lane enables are captured on each rising clock edge. The data bus is modelled as three signals: an input word, an output word and a drive enable.

A static mode input selects one of two timings. In registered mode, read data passes through an output register and write data is taken two edges after its command. In direct mode, read data comes straight from the array and write data is taken one edge after its command. Because the read-data slot and the write-data slot fall in different cycles, the bus stays in use on every cycle under any mix of reads and writes.

Three chip enables must all be active for a cycle to be selected, which lets several cores share one bus for depth expansion. An output-enable input and a sleep input both act at once, without waiting for the clock, to stop the data drivers. A read that hits a write still waiting for its data returns that pending data, merged per lane.

Top module: `lw_sram_core`

## Requirements
- R1: A command is accepted at a rising edge only when ce0_n=0, ce1=1, ce2_n=0 and sleep=0 there. Any other combination leaves the array unchanged and produces no read output.
- R2: In registered mode (pipe_mode=1), a read accepted at edge k drives d_oe=1 with the addressed word on d_out between edge k+1 and edge k+2.
- R3: In direct mode (pipe_mode=0), a read accepted at edge k drives d_oe=1 with the addressed word on d_out between edge k and edge k+1.
- R4: In registered mode, the data of a write accepted at edge k is taken from d_in at edge k+2.
- R5: In direct mode, the data of a write accepted at edge k is taken from d_in at edge k+1.
- R6: Lane i covers bits [9i+8:9i]. It is written only when lane_wr_n[i]=0 at the edge where the write command is accepted. Other lanes keep their contents.
- R7: A read returns the lane-merged result of every write accepted before it, including a write whose data is still in flight.
- R8: Reads and writes may alternate on consecutive edges in either mode. d_oe is 0 in every cycle whose d_in carries late write data.
- R9: oe_n=1 forces d_oe to 0 at once, without waiting for a clock edge. Lowering it again restores the drive for a read that is still valid.
- R10: While sleep=1, d_oe is 0 at once, new commands are ignored and stored contents are kept. Writes accepted before sleep still complete.
- R11: While rst_n=0 and after its release, d_oe is 0 until a read is accepted.
- R12: we_n=0 in an accepted cycle selects a write; we_n=1 selects a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| pipe_mode | input | 1 | 1 = registered mode, 0 = direct mode (static) |
| sleep | input | 1 | Power-down request; blocks commands and drive |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write, 1 = read |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | 6 | Word address |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| d_in | input | 36 | Bus data arriving at the core |
| d_out | output | 36 | Read data |
| d_oe | output | 1 | Drive enable for d_out |

## Verification
Isolated writes followed by reads, in both modes, confirm the separate read and write latencies. Alternating read/write runs with no gap show that the drive slot and the write-data slot never overlap. Partial-lane writes followed straight away by a read of the same address separate a correct forward-and-merge from a stale array read. Deselected and sleeping commands are driven with distinct data on d_in, so any wrongly accepted write shows up in a later read. Toggling oe_n and sleep in the middle of a cycle shows that they stop the drive without waiting for a clock edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    parameter int LW_ADDR_W = 6;
    parameter int LW_LANES  = 4;
    parameter int LW_LANE_W = 9;
    localparam int LW_DATA_W = LW_LANES * LW_LANE_W;
    localparam int LW_DEPTH  = 1 << LW_ADDR_W;

    typedef struct packed {
        logic                 vld;
        logic                 wr;
        logic [LW_ADDR_W-1:0] addr;
        logic [LW_LANES-1:0]  lane_en;
    } lw_cmd_t;
endpackage

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr_n,
    input  logic [LW_LANES-1:0]  lane_n,
    input  logic [LW_ADDR_W-1:0] addr,
    output lw_cmd_t              stg1,
    output lw_cmd_t              stg2
);
    typedef struct packed {
        lw_cmd_t s1;
        lw_cmd_t s2;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.s1.vld     = sel;
        st_d.s1.wr      = !wr_n;
        st_d.s1.addr    = addr;
        st_d.s1.lane_en = ~lane_n;
        st_d.s2         = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stg1 = st_q.s1;
    assign stg2 = st_q.s2;
endmodule

// File: rtl/lw_store.sv
module lw_store
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [LW_ADDR_W-1:0] wr_addr,
    input  logic [LW_LANES-1:0]  wr_lanes,
    input  logic [LW_DATA_W-1:0] wr_data,
    input  logic [LW_ADDR_W-1:0] rd_addr,
    output logic [LW_DATA_W-1:0] rd_data
);
    logic [LW_DATA_W-1:0] mem_q [LW_DEPTH];
    logic [LW_DATA_W-1:0] old_word;
    logic [LW_DATA_W-1:0] word_d;

    assign old_word = mem_q[wr_addr];

    for (genvar g = 0; g < LW_LANES; g++) begin : g_lane
        assign word_d[g*LW_LANE_W +: LW_LANE_W] = wr_lanes[g]
            ? wr_data[g*LW_LANE_W +: LW_LANE_W]
            : old_word[g*LW_LANE_W +: LW_LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= word_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/lw_rd_path.sv
module lw_rd_path
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_mode,
    input  logic                 rd_vld,
    input  logic [LW_ADDR_W-1:0] rd_addr,
    input  lw_cmd_t              fw_cmd,
    input  logic [LW_DATA_W-1:0] d_in,
    input  logic [LW_DATA_W-1:0] arr_word,
    input  logic                 oe_n,
    input  logic                 sleep,
    output logic [LW_DATA_W-1:0] d_out,
    output logic                 d_oe
);
    typedef struct packed {
        logic                 vld;
        logic [LW_DATA_W-1:0] word;
    } out_t;

    out_t st_d, st_q;
    logic hit;
    logic live;
    logic [LW_DATA_W-1:0] fwd_word;

    // a write waiting for its late data on this cycle's bus
    assign hit = fw_cmd.vld && fw_cmd.wr && (fw_cmd.addr == rd_addr);

    for (genvar g = 0; g < LW_LANES; g++) begin : g_fwd
        assign fwd_word[g*LW_LANE_W +: LW_LANE_W] = (hit && fw_cmd.lane_en[g])
            ? d_in[g*LW_LANE_W +: LW_LANE_W]
            : arr_word[g*LW_LANE_W +: LW_LANE_W];
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = rd_vld;
        if (rd_vld) st_d.word = fwd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (pipe_mode) begin
            d_out = st_q.word;
            live  = st_q.vld;
        end else begin
            d_out = arr_word;
            live  = rd_vld;
        end
        d_oe = live && !oe_n && !sleep;
    end
endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_mode,
    input  logic                 sleep,
    input  logic                 ce0_n,
    input  logic                 ce1,
    input  logic                 ce2_n,
    input  logic                 we_n,
    input  logic [LW_LANES-1:0]  lane_wr_n,
    input  logic [LW_ADDR_W-1:0] addr,
    input  logic                 oe_n,
    input  logic [LW_DATA_W-1:0] d_in,
    output logic [LW_DATA_W-1:0] d_out,
    output logic                 d_oe
);
    lw_cmd_t s1, s2, wr_src;
    logic sel;
    logic [LW_DATA_W-1:0] arr_word;

    assign sel = !ce0_n && ce1 && !ce2_n && !sleep;

    lw_cmd_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wr_n   (we_n),
        .lane_n (lane_wr_n),
        .addr   (addr),
        .stg1   (s1),
        .stg2   (s2)
    );

    // the write port retires the stage whose data is on the bus now
    assign wr_src = pipe_mode ? s2 : s1;

    lw_store u_store (
        .clk      (clk),
        .wr_en    (wr_src.vld && wr_src.wr),
        .wr_addr  (wr_src.addr),
        .wr_lanes (wr_src.lane_en),
        .wr_data  (d_in),
        .rd_addr  (s1.addr),
        .rd_data  (arr_word)
    );

    lw_rd_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .rd_vld    (s1.vld && !s1.wr),
        .rd_addr   (s1.addr),
        .fw_cmd    (s2),
        .d_in      (d_in),
        .arr_word  (arr_word),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .d_out     (d_out),
        .d_oe      (d_oe)
    );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic pipe_mode,
    input logic sleep,
    input logic ce0_n,
    input logic ce1,
    input logic ce2_n,
    input logic we_n,
    input logic oe_n,
    input logic d_oe
);
    logic go, rd_go, wr_go;
    assign go    = !ce0_n && ce1 && !ce2_n && !sleep;
    assign rd_go = go && we_n;
    assign wr_go = go && !we_n;

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !d_oe);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !d_oe);

    // R2
    pipe_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && d_oe) |-> $past(rd_go, 2));

    // R3
    flow_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && d_oe) |-> $past(rd_go));

    // R8
    pipe_wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(wr_go, 2)) |-> !d_oe);

    // R8
    flow_wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && $past(wr_go)) |-> !d_oe);
endmodule

bind lw_sram_core lw_sram_chk u_chk (.*);

// File: tb/tb_lw_sram_core.sv
`timescale 1ns/1ps
module tb_lw_sram_core;
    import lw_sram_pkg::*;

    localparam logic [LW_DATA_W-1:0] JUNK = 36'h5_A5A5_A5A5;
    localparam logic [2:0] CE_ON = 3'b010;  // {ce2_n, ce1, ce0_n}

    logic clk = 1'b0;
    logic rst_n, pipe_mode, sleep, ce0_n, ce1, ce2_n, we_n, oe_n;
    logic [LW_LANES-1:0]  lane_wr_n;
    logic [LW_ADDR_W-1:0] addr;
    logic [LW_DATA_W-1:0] d_in, d_out;
    logic d_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic [1:0]           op_kind [0:31];
    logic [LW_ADDR_W-1:0] op_addr [0:31];
    logic [LW_LANES-1:0]  op_bw   [0:31];
    logic [LW_DATA_W-1:0] op_data [0:31];
    logic [2:0]           op_ce   [0:31];
    logic                 op_slp  [0:31];
    logic                 exp_v   [0:31];
    logic [LW_DATA_W-1:0] exp_w   [0:31];
    logic [LW_DATA_W-1:0] ref_mem [0:LW_DEPTH-1];
    int n_ops = 0;

    always #4 clk = ~clk;

    lw_sram_core dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .we_n(we_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .oe_n(oe_n),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    task automatic chk(input string tag, input logic [LW_DATA_W-1:0] act,
                       input logic [LW_DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [LW_DATA_W-1:0] merge(input logic [LW_DATA_W-1:0] old_w,
            input logic [LW_DATA_W-1:0] new_w, input logic [LW_LANES-1:0] bwn);
        logic [LW_DATA_W-1:0] r = old_w;
        for (int i = 0; i < LW_LANES; i++)
            if (!bwn[i]) r[i*LW_LANE_W +: LW_LANE_W] = new_w[i*LW_LANE_W +: LW_LANE_W];
        return r;
    endfunction

    task automatic drive_idle();
        {ce2_n, ce1, ce0_n} = 3'b011;
        we_n = 1'b1; lane_wr_n = '1; addr = '0; sleep = 1'b0;
    endtask

    // kind: 0 idle, 1 read, 2 write
    task automatic add_op(input logic [1:0] k, input logic [LW_ADDR_W-1:0] a,
                          input logic [LW_LANES-1:0] bwn, input logic [LW_DATA_W-1:0] dat,
                          input logic [2:0] ce = CE_ON, input logic slp = 1'b0);
        op_kind[n_ops] = k; op_addr[n_ops] = a; op_bw[n_ops] = bwn;
        op_data[n_ops] = dat; op_ce[n_ops] = ce; op_slp[n_ops] = slp;
        n_ops++;
    endtask

    // Issues the queued ops one per edge; places late write data and checks
    // each command's output slot from the reference model.
    task automatic run_seq(input string tag);
        int dly = pipe_mode ? 2 : 1;
        for (int t = 0; t < n_ops + dly + 1; t++) begin
            int c = t - dly;
            logic take;
            @(negedge clk);
            if (c >= 0 && c < n_ops) begin
                if (exp_v[c] && !sleep) begin
                    chk({tag, " drive"}, {35'b0, d_oe}, 36'd1);
                    chk({tag, " data"}, d_out, exp_w[c]);
                end else begin
                    chk({tag, " no drive"}, {35'b0, d_oe}, 36'd0);
                end
            end
            if (c >= 0 && c < n_ops && op_kind[c] == 2'd2) d_in = op_data[c];
            else d_in = JUNK;
            if (t < n_ops) begin
                if (op_kind[t] == 2'd0) drive_idle();
                else begin
                    {ce2_n, ce1, ce0_n} = op_ce[t];
                    sleep = op_slp[t];
                    we_n = (op_kind[t] != 2'd2);
                    lane_wr_n = op_bw[t];
                    addr = op_addr[t];
                end
                take = (op_kind[t] != 2'd0) && (op_ce[t] == CE_ON) && !op_slp[t];
                exp_v[t] = take && (op_kind[t] == 2'd1);
                if (exp_v[t]) exp_w[t] = ref_mem[op_addr[t]];
                if (take && op_kind[t] == 2'd2)
                    ref_mem[op_addr[t]] = merge(ref_mem[op_addr[t]], op_data[t], op_bw[t]);
            end else begin
                drive_idle();
            end
        end
        n_ops = 0;
    endtask

    task automatic set_mode(input logic p);
        @(negedge clk);
        drive_idle();
        pipe_mode = p;
        repeat (3) @(negedge clk);
    endtask

    // R11: no drive during and right after reset
    task automatic t_reset();
        rst_n = 1'b0; pipe_mode = 1'b1; oe_n = 1'b0; d_in = JUNK;
        drive_idle();
        repeat (3) @(negedge clk);
        chk("R11 in reset", {35'b0, d_oe}, 36'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 after reset", {35'b0, d_oe}, 36'd0);
    endtask

    // R3 R5 R12: direct mode timing
    task automatic t_flow_basic();
        set_mode(1'b0);
        add_op(2, 6'd1, 4'h0, 36'h1_1111_0001);
        add_op(2, 6'd2, 4'h0, 36'h2_2222_0002);
        add_op(0, 0, 4'hF, 0);
        add_op(1, 6'd1, 4'hF, 0);
        add_op(1, 6'd2, 4'hF, 0);
        run_seq("R3 R5 R12 direct");
    endtask

    // R2 R4: registered mode timing
    task automatic t_pipe_basic();
        set_mode(1'b1);
        add_op(2, 6'd10, 4'h0, 36'hA_0000_000A);
        add_op(2, 6'd11, 4'h0, 36'hB_0000_000B);
        add_op(0, 0, 4'hF, 0);
        add_op(0, 0, 4'hF, 0);
        add_op(1, 6'd10, 4'hF, 0);
        add_op(1, 6'd11, 4'hF, 0);
        run_seq("R2 R4 registered");
    endtask

    // R6: lane writes
    task automatic t_lanes();
        set_mode(1'b1);
        add_op(2, 6'd3, 4'h0, 36'hF_FFFF_FFFF);
        add_op(2, 6'd3, 4'b1010, 36'h0_0000_0000);
        add_op(0, 0, 4'hF, 0);
        add_op(0, 0, 4'hF, 0);
        add_op(1, 6'd3, 4'hF, 0);
        add_op(2, 6'd3, 4'b0111, 36'h1_2345_6789);
        add_op(0, 0, 4'hF, 0);
        add_op(0, 0, 4'hF, 0);
        add_op(1, 6'd3, 4'hF, 0);
        run_seq("R6 lanes");
    endtask

    // R7: read right behind a pending partial write
    task automatic t_forward();
        set_mode(1'b1);
        add_op(2, 6'd4, 4'h0, 36'h3_3333_3333);
        add_op(0, 0, 4'hF, 0);
        add_op(0, 0, 4'hF, 0);
        add_op(2, 6'd4, 4'b0101, 36'hC_CCCC_CCCC);
        add_op(1, 6'd4, 4'hF, 0);
        add_op(2, 6'd4, 4'b1110, 36'h7_7777_7777);
        add_op(1, 6'd4, 4'hF, 0);
        add_op(1, 6'd4, 4'hF, 0);
        run_seq("R7 registered forward");
        set_mode(1'b0);
        add_op(2, 6'd4, 4'b0011, 36'h9_9999_9999);
        add_op(1, 6'd4, 4'hF, 0);
        run_seq("R7 direct");
    endtask

    // R8: gapless turnaround in both modes
    task automatic t_turn();
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            add_op(2, 6'd20, 4'h0, 36'h0_1357_9BDF + 36'(m));
            add_op(1, 6'd20, 4'hF, 0);
            add_op(2, 6'd21, 4'h0, 36'h8_2468_ACE0 + 36'(m));
            add_op(1, 6'd21, 4'hF, 0);
            add_op(1, 6'd20, 4'hF, 0);
            add_op(2, 6'd20, 4'h0, 36'h4_0F0F_0F0F + 36'(m));
            add_op(1, 6'd20, 4'hF, 0);
            add_op(2, 6'd21, 4'h0, 36'h6_F0F0_F0F0 + 36'(m));
            add_op(2, 6'd20, 4'h0, 36'h2_DEAD_BEEF + 36'(m));
            add_op(1, 6'd21, 4'hF, 0);
            add_op(1, 6'd20, 4'hF, 0);
            run_seq("R8 turnaround");
        end
    endtask

    // R1: each chip enable alone blocks the cycle
    task automatic t_enables();
        set_mode(1'b1);
        add_op(2, 6'd9, 4'h0, 36'h5_0505_0505);
        add_op(2, 6'd9, 4'h0, 36'hE_1111_1111, 3'b011);
        add_op(1, 6'd9, 4'hF, 0, 3'b011);
        add_op(2, 6'd9, 4'h0, 36'hE_2222_2222, 3'b000);
        add_op(1, 6'd9, 4'hF, 0, 3'b000);
        add_op(2, 6'd9, 4'h0, 36'hE_3333_3333, 3'b110);
        add_op(1, 6'd9, 4'hF, 0, 3'b110);
        add_op(0, 0, 4'hF, 0);
        add_op(1, 6'd9, 4'hF, 0);
        run_seq("R1 enables");
    endtask

    // R9 and R10: asynchronous drive cut mid-cycle
    task automatic t_oe();
        set_mode(1'b1);
        add_op(2, 6'd5, 4'h0, 36'h6_6660_0666);
        run_seq("R9 setup");
        @(negedge clk);
        {ce2_n, ce1, ce0_n} = CE_ON; we_n = 1'b1; addr = 6'd5;
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        chk("R2 before oe", {35'b0, d_oe}, 36'd1);
        chk("R2 data", d_out, 36'h6_6660_0666);
        oe_n = 1'b1; #1;
        chk("R9 oe_n high", {35'b0, d_oe}, 36'd0);
        oe_n = 1'b0; #1;
        chk("R9 oe_n low again", {35'b0, d_oe}, 36'd1);
        sleep = 1'b1; #1;
        chk("R10 sleep cuts drive", {35'b0, d_oe}, 36'd0);
        sleep = 1'b0; #1;
        @(negedge clk);
        drive_idle();
    endtask

    // R10: commands ignored while asleep, contents kept
    task automatic t_sleep();
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            add_op(2, 6'd7, 4'h0, 36'h4_4444_0000 + 36'(m));
            add_op(2, 6'd7, 4'h0, 36'hB_BBBB_BBBB, CE_ON, 1'b1);
            add_op(1, 6'd7, 4'hF, 0, CE_ON, 1'b1);
            add_op(2, 6'd8, 4'h0, 36'hB_BBBB_0000, CE_ON, 1'b1);
            add_op(0, 0, 4'hF, 0);
            add_op(1, 6'd7, 4'hF, 0);
            run_seq("R10 sleep");
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_flow_basic();
        t_pipe_basic();
        t_lanes();
        t_forward();
        t_turn();
        t_enables();
        t_oe();
        t_sleep();
        report();
        $finish;
    end
endmodule